// File: doc/BRIEF.md
# Fixed Off-Time Mixed-Decay Chopper

This block sequences the current regulation of one full bridge. While driving, it enables the diagonal pair of switches that matches the commanded direction. When the external sense comparator reports that the winding current has reached its limit, the block ends the drive phase and runs a fixed off-time. The first half of the off-time is fast decay, with the opposite diagonal enabled. The second half is slow decay, with both low-side switches on. Every change between phases passes through an all-off dead gap, so no leg ever has both of its switches on at the same moment.

Trips that arrive in the first cycles of a drive phase are masked by a blanking window, which hides the turn-on current spike. A zero-current detect input turns off synchronous rectification for the rest of the off-time, so the winding current cannot reverse. A change of the direction input abandons the running sequence: the block goes to a dead gap and then starts a fresh drive phase in the new direction. All durations are parameters counted in clock cycles. The outputs are per-leg switch states for the downstream gate decoder.

Top module: `mixed_decay_chopper`

## Requirements
- R1: The `phase` output is coded as follows: 0 = gap before drive, 1 = drive, 2 = gap before fast decay, 3 = fast decay, 4 = gap before slow decay, 5 = slow decay. While reset is held and in the first cycle after reset, `phase` is 0 and both legs are off. Drive begins after DEAD_CYC cycles.
- R2: Each leg is coded as {high switch, low switch}: 2'b10 = high, 2'b01 = low, 2'b00 = off. In drive with `dir_fwd`=1, leg A is high and leg B is low. With `dir_fwd`=0, leg A is low and leg B is high.
- R3: A trip is ignored during the first BLANK_CYC cycles of a drive phase. From the next cycle on, a trip moves `phase` to 2 on the following clock edge.
- R4: Each of the three gaps (before fast decay, before slow decay, before drive) lasts DEAD_CYC cycles, with both legs off.
- R5: Fast decay lasts OFF_CYC/2 cycles (rounded down) and enables the diagonal opposite to the drive diagonal.
- R6: Slow decay lasts OFF_CYC minus the fast-decay length, with both legs low.
- R7: When `zero_cur` is high in a fast-decay or slow-decay cycle, both legs are off from the next cycle until the next drive phase.
- R8: After the off-time and its gap, drive resumes on the same diagonal, with rectification restored and blanking restarted.
- R9: When `dir_fwd` differs from the latched direction, the next cycle is in phase 0. The following drive phase uses the new direction.
- R10: No leg ever shows 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_fwd | input | 1 | Commanded direction, 1 = forward |
| trip | input | 1 | Sense comparator: current at its limit |
| zero_cur | input | 1 | Winding current has reached zero |
| phase | output | 3 | Current sequencer phase (R1 coding) |
| leg_a | output | 2 | Leg A switch state {high, low} |
| leg_b | output | 2 | Leg B switch state {high, low} |

## Verification
The hardest situations to reach are a zero-current detect inside a decay phase, and a direction change in the middle of an off-time. Both need the sequencer to be in a narrow phase at the moment the input moves. Directed sequences hold the trip line until the blanking window opens, then pulse `zero_cur` or flip `dir_fwd` at counted cycles. A long random run with sparse zero detects and rare direction flips then lands these events in every phase, including the gaps. It is checked cycle by cycle against a bench model.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [2:0] {
        PH_GAP_DRV  = 3'd0,
        PH_DRIVE    = 3'd1,
        PH_GAP_FAST = 3'd2,
        PH_FAST     = 3'd3,
        PH_GAP_SLOW = 3'd4,
        PH_SLOW     = 3'd5
    } phase_e;

    typedef enum logic [1:0] {
        LEG_OFF  = 2'b00,
        LEG_LOW  = 2'b01,
        LEG_HIGH = 2'b10
    } leg_e;

    typedef struct packed {
        leg_e a;
        leg_e b;
    } bridge_t;

    function automatic bridge_t bridge_for(phase_e ph, logic fwd, logic sr_off);
        bridge_t r;
        r.a = LEG_OFF;
        r.b = LEG_OFF;
        case (ph)
            PH_DRIVE: begin
                r.a = fwd ? LEG_HIGH : LEG_LOW;
                r.b = fwd ? LEG_LOW  : LEG_HIGH;
            end
            PH_FAST: if (!sr_off) begin
                r.a = fwd ? LEG_LOW  : LEG_HIGH;
                r.b = fwd ? LEG_HIGH : LEG_LOW;
            end
            PH_SLOW: if (!sr_off) begin
                r.a = LEG_LOW;
                r.b = LEG_LOW;
            end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] TOP = {CW{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (cnt != TOP)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/chop_seq.sv
module chop_seq
    import chop_pkg::*;
#(
    parameter int DEAD_CYC  = 20,
    parameter int FAST_CYC  = 2500,
    parameter int SLOW_CYC  = 2500,
    parameter int BLANK_CYC = 600,
    parameter int CW        = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dir_fwd,
    input  logic          trip,
    input  logic          zero_cur,
    input  logic [CW-1:0] cnt,
    output phase_e        phase,
    output logic          fwd,
    output logic          sr_off,
    output logic          clear
);
    localparam logic [CW-1:0] DEAD_LAST = CW'(DEAD_CYC - 1);
    localparam logic [CW-1:0] FAST_LAST = CW'(FAST_CYC - 1);
    localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_CYC - 1);
    localparam logic [CW-1:0] BLANK_V   = CW'(BLANK_CYC);

    phase_e ph_n;
    logic   fwd_n, sr_n;
    logic   blank_done;

    assign blank_done = (cnt >= BLANK_V);

    always_comb begin
        ph_n  = phase;
        fwd_n = fwd;
        sr_n  = sr_off;
        clear = 1'b0;
        if (dir_fwd != fwd) begin
            ph_n  = PH_GAP_DRV;
            fwd_n = dir_fwd;
            sr_n  = 1'b0;
            clear = 1'b1;
        end else begin
            case (phase)
                PH_GAP_DRV: if (cnt == DEAD_LAST) begin
                    ph_n  = PH_DRIVE;
                    sr_n  = 1'b0;
                    clear = 1'b1;
                end
                PH_DRIVE: if (trip && blank_done) begin
                    ph_n  = PH_GAP_FAST;
                    clear = 1'b1;
                end
                PH_GAP_FAST: if (cnt == DEAD_LAST) begin
                    ph_n  = PH_FAST;
                    clear = 1'b1;
                end
                PH_FAST: begin
                    if (zero_cur) sr_n = 1'b1;
                    if (cnt == FAST_LAST) begin
                        ph_n  = PH_GAP_SLOW;
                        clear = 1'b1;
                    end
                end
                PH_GAP_SLOW: if (cnt == DEAD_LAST) begin
                    ph_n  = PH_SLOW;
                    clear = 1'b1;
                end
                PH_SLOW: begin
                    if (zero_cur) sr_n = 1'b1;
                    if (cnt == SLOW_LAST) begin
                        ph_n  = PH_GAP_DRV;
                        clear = 1'b1;
                    end
                end
                default: begin
                    ph_n  = PH_GAP_DRV;
                    clear = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_GAP_DRV;
            fwd    <= 1'b1;
            sr_off <= 1'b0;
        end else begin
            phase  <= ph_n;
            fwd    <= fwd_n;
            sr_off <= sr_n;
        end
    end

    // R3
    blank_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DRIVE && cnt < BLANK_V && dir_fwd == fwd) |=> phase == PH_DRIVE);

    // R9
    dir_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (dir_fwd != fwd) |=> (phase == PH_GAP_DRV && fwd == $past(dir_fwd)));

    // R4
    gap_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_GAP_SLOW) |=> (phase inside {PH_GAP_SLOW, PH_SLOW, PH_GAP_DRV}));

endmodule

// File: rtl/chop_bridge_map.sv
module chop_bridge_map
    import chop_pkg::*;
(
    input  phase_e  phase,
    input  logic    fwd,
    input  logic    sr_off,
    output bridge_t bridge
);
    assign bridge = bridge_for(phase, fwd, sr_off);
endmodule

// File: rtl/mixed_decay_chopper.sv
module mixed_decay_chopper
    import chop_pkg::*;
#(
    parameter int OFF_CYC   = 5000,
    parameter int DEAD_CYC  = 20,
    parameter int BLANK_CYC = 600
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dir_fwd,
    input  logic       trip,
    input  logic       zero_cur,
    output logic [2:0] phase,
    output logic [1:0] leg_a,
    output logic [1:0] leg_b
);
    localparam int FAST_CYC = OFF_CYC / 2;
    localparam int SLOW_CYC = OFF_CYC - FAST_CYC;
    localparam int MAX_A    = (SLOW_CYC > DEAD_CYC) ? SLOW_CYC : DEAD_CYC;
    localparam int MAX_V    = (MAX_A > BLANK_CYC) ? MAX_A : BLANK_CYC;
    localparam int CW       = $clog2(MAX_V + 1);

    logic [CW-1:0] cnt;
    logic          clear, fwd, sr_off;
    phase_e        ph;
    bridge_t       br;

    chop_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .clear(clear), .cnt(cnt)
    );

    chop_seq #(
        .DEAD_CYC(DEAD_CYC), .FAST_CYC(FAST_CYC), .SLOW_CYC(SLOW_CYC),
        .BLANK_CYC(BLANK_CYC), .CW(CW)
    ) u_seq (
        .clk(clk), .rst(rst), .dir_fwd(dir_fwd), .trip(trip),
        .zero_cur(zero_cur), .cnt(cnt), .phase(ph), .fwd(fwd),
        .sr_off(sr_off), .clear(clear)
    );

    chop_bridge_map u_map (
        .phase(ph), .fwd(fwd), .sr_off(sr_off), .bridge(br)
    );

    assign phase = ph;
    assign leg_a = br.a;
    assign leg_b = br.b;

    // R10
    no_shoot_chk: assert property (@(posedge clk) disable iff (rst)
        (leg_a != 2'b11) && (leg_b != 2'b11));

    // R4
    gap_off_chk: assert property (@(posedge clk) disable iff (rst)
        (ph inside {PH_GAP_DRV, PH_GAP_FAST, PH_GAP_SLOW}) |-> (leg_a == 2'b00 && leg_b == 2'b00));

    // R7
    rect_off_chk: assert property (@(posedge clk) disable iff (rst)
        (sr_off && ph inside {PH_FAST, PH_SLOW}) |-> (leg_a == 2'b00 && leg_b == 2'b00));

endmodule

// File: tb/mixed_decay_chopper_bench.sv
`timescale 1ns/1ps
module mixed_decay_chopper_bench;
    localparam int DEAD  = 3;
    localparam int OFF   = 21;
    localparam int BLANK = 5;
    localparam int FASTL = OFF / 2;
    localparam int SLOWL = OFF - FASTL;

    logic clk = 1'b0;
    logic rst = 1'b1, dir_fwd = 1'b1, trip = 1'b0, zero_cur = 1'b0;
    logic [2:0] phase;
    logic [1:0] leg_a, leg_b;

    int checks = 0, fails = 0;
    int m_ph = 0, m_cnt = 0;
    bit m_dir = 1'b1, m_sroff = 1'b0;

    always #2.5 clk = ~clk;

    mixed_decay_chopper #(.OFF_CYC(OFF), .DEAD_CYC(DEAD), .BLANK_CYC(BLANK)) u_mixed_decay_chopper (
        .clk(clk), .rst(rst), .dir_fwd(dir_fwd), .trip(trip), .zero_cur(zero_cur),
        .phase(phase), .leg_a(leg_a), .leg_b(leg_b)
    );

    function automatic logic [3:0] exp_legs(int ph, bit d, bit so);
        case (ph)
            1: return d ? 4'b1001 : 4'b0110;
            3: return so ? 4'b0000 : (d ? 4'b0110 : 4'b1001);
            5: return so ? 4'b0000 : 4'b0101;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic string tag_of(int ph, bit so);
        if (so && (ph == 3 || ph == 5)) return "R7";
        case (ph)
            1: return "R2";
            3: return "R5";
            5: return "R6";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model(bit t, bit z, bit d);
        if (rst) begin
            m_ph = 0; m_cnt = 0; m_dir = 1'b1; m_sroff = 1'b0;
        end else if (d != m_dir) begin
            m_ph = 0; m_cnt = 0; m_dir = d; m_sroff = 1'b0;
        end else begin
            case (m_ph)
                0, 2, 4: if (m_cnt == DEAD - 1) begin
                    if (m_ph == 0) m_sroff = 1'b0;
                    m_ph = m_ph + 1; m_cnt = 0;
                end else m_cnt++;
                1: if (t && m_cnt >= BLANK) begin m_ph = 2; m_cnt = 0; end
                   else m_cnt++;
                3: begin
                    if (z) m_sroff = 1'b1;
                    if (m_cnt == FASTL - 1) begin m_ph = 4; m_cnt = 0; end else m_cnt++;
                end
                default: begin
                    if (z) m_sroff = 1'b1;
                    if (m_cnt == SLOWL - 1) begin m_ph = 0; m_cnt = 0; end else m_cnt++;
                end
            endcase
        end
    endtask

    task automatic step(bit t, bit z, bit d);
        trip = t; zero_cur = z; dir_fwd = d;
        model(t, z, d);
        @(posedge clk);
        #1;
        chk(tag_of(m_ph, m_sroff), int'(phase), m_ph);
        chk(tag_of(m_ph, m_sroff), int'({leg_a, leg_b}), int'(exp_legs(m_ph, m_dir, m_sroff)));
        chk("R10", int'(leg_a == 2'b11 || leg_b == 2'b11), 0);
    endtask

    task automatic run_while(int code, bit t, bit z, bit d, output int n);
        n = 0;
        while (int'(phase) == code && n < 1000) begin
            step(t, z, d);
            n++;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int n;
        bit d;
        rst = 1'b1;
        for (int i = 0; i < 3; i++) step(0, 0, 1);
        chk("R1", int'(phase), 0);
        chk("R1", int'({leg_a, leg_b}), 0);
        rst = 1'b0;
        for (int i = 0; i < DEAD - 1; i++) step(0, 0, 1);
        chk("R1", int'(phase), 0);
        step(0, 0, 1);
        chk("R2", int'(phase), 1);
        chk("R2", int'({leg_a, leg_b}), 4'b1001);

        run_while(1, 1, 0, 1, n);
        chk("R3", n, BLANK + 1);
        run_while(2, 0, 0, 1, n);
        chk("R4", n, DEAD);
        chk("R5", int'({leg_a, leg_b}), 4'b0110);
        run_while(3, 0, 0, 1, n);
        chk("R5", n, FASTL);
        run_while(4, 0, 0, 1, n);
        chk("R4", n, DEAD);
        chk("R6", int'({leg_a, leg_b}), 4'b0101);
        run_while(5, 0, 0, 1, n);
        chk("R6", n, SLOWL);
        run_while(0, 0, 0, 1, n);
        chk("R4", n, DEAD);
        chk("R8", int'(phase), 1);
        chk("R8", int'({leg_a, leg_b}), 4'b1001);
        run_while(1, 1, 0, 1, n);
        chk("R8", n, BLANK + 1);

        run_while(2, 0, 0, 1, n);
        step(0, 0, 0);
        chk("R9", int'(phase), 0);
        run_while(0, 0, 0, 0, n);
        chk("R9", n, DEAD);
        chk("R9", int'({leg_a, leg_b}), 4'b0110);

        run_while(1, 1, 0, 0, n);
        run_while(2, 0, 0, 0, n);
        chk("R5", int'({leg_a, leg_b}), 4'b1001);
        step(0, 1, 0);
        chk("R7", int'({leg_a, leg_b}), 0);
        run_while(3, 0, 0, 0, n);
        run_while(4, 0, 0, 0, n);
        chk("R7", int'(phase), 5);
        chk("R7", int'({leg_a, leg_b}), 0);
        run_while(5, 0, 0, 0, n);
        run_while(0, 0, 0, 0, n);
        chk("R8", int'({leg_a, leg_b}), 4'b0110);

        void'($urandom(32'h5eed));
        d = 1'b0;
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 299) == 0) d = ~d;
            step($urandom_range(0, 3) == 0, $urandom_range(0, 39) == 0, d);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule